// File: doc/BRIEF.md
# Change-Detecting Input/Output Controller

This block connects a set of external input bytes and one external result byte to a shared memory bus. It keeps a stored copy of every input. When the sequencer requests a scan, it visits the inputs one at a time, from the lowest index to the highest. For each input it compares the live value with the stored copy. Each input that differs is written into its own memory slot, and the stored copy takes the new value once the bus accepts that write.

When the scan ends, the block gives a one-cycle done pulse. A flag alongside the pulse tells the sequencer whether any write took place. A done pulse with the flag low lets the sequencer skip starting the processor.

When asked to fetch, the block reads the result byte from a fixed memory address. It presents that byte on a held output with a one-cycle valid pulse.

A bus access uses a request/grant handshake. The access completes on the clock edge where both request and grant are high. Read data is sampled on that same edge. The bus carries 8-bit data and 16-bit addresses.

Top module: `chg_io_ctrl`

## Requirements
- R1: With no scan or fetch request, the block makes no bus request and gives no done pulse, even when the external inputs change.
- R2: During a scan, each input i whose value differs from its stored copy is written exactly once, to address IN_BASE + i (default 16'h0100), with the input's current byte as data and bus_we_o high. Writes come in ascending index order, and unchanged inputs produce no write. Input i occupies bits [8*i+7:8*i] of in_data_i.
- R3: While a request is not granted, request, address, write data and direction stay stable. The stored copy of an input changes only when its write is granted, so a delayed grant never causes a duplicate or a missing write.
- R4: A scan ends with a single-cycle scan_done_o pulse. On that cycle changed_o is 1 if the scan wrote at least one input and 0 if it wrote none.
- R5: A second scan with unchanged inputs performs no writes and reports changed_o = 0.
- R6: A fetch reads address RES_ADDR (default 16'h0200) with bus_we_o low. It loads the granted read data into res_data_o and pulses res_valid_o for one cycle. res_data_o then holds until the next completed read.
- R7: After reset, bus_req_o, scan_done_o, changed_o and res_valid_o are 0, res_data_o is 0, and every stored copy is 0.
- R8: If scan and fetch requests arrive in the same idle cycle, the scan is taken and the fetch request is dropped.
- R9: Scan or fetch requests that arrive while an access is in progress are ignored, not queued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_data_i | input | NUM_IN*8 | External input bytes, input i in bits [8i+7:8i] |
| scan_req_i | input | 1 | Request to compare the inputs and write back the changed ones |
| fetch_req_i | input | 1 | Request to read the result byte from memory |
| scan_done_o | output | 1 | One-cycle pulse when a scan ends |
| changed_o | output | 1 | Set if the last scan wrote at least one input |
| res_data_o | output | 8 | Last result byte read from memory |
| res_valid_o | output | 1 | One-cycle pulse when res_data_o is updated |
| bus_req_o | output | 1 | Bus access request |
| bus_gnt_i | input | 1 | Bus grant; the access completes on an edge where req and grant are both high |
| bus_we_o | output | 1 | 1 for a write, 0 for a read |
| bus_addr_o | output | 16 | Bus address |
| bus_wdata_o | output | 8 | Write data |
| bus_rdata_i | input | 8 | Read data, sampled on the granting edge |

## Verification
The hardest situation to reach from the ports is a write left waiting for grant over several cycles, in the middle of a scan whose changed inputs are not adjacent. This is where a broken hold or an early update of the stored copy would show up as a duplicated, lost or misaddressed write. The bench bus model adds a grant delay that changes from vector to vector. The vector sequence is chosen so that the stored copies leave changed inputs at the ends, in the middle, and in every position.

// File: rtl/chg_io_pkg.sv
package chg_io_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SCAN  = 2'd1,
    ST_WRITE = 2'd2,
    ST_READ  = 2'd3
  } io_state_t;
endpackage

// File: rtl/chg_io_shadow.sv
module chg_io_shadow #(
  parameter int NUM_IN = 4,
  parameter int DATA_W = 8,
  localparam int IDX_W = (NUM_IN > 1) ? $clog2(NUM_IN) : 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NUM_IN*DATA_W-1:0] in_data_i,
  input  logic [IDX_W-1:0]         sel_i,
  input  logic                     upd_i,
  input  logic [DATA_W-1:0]        upd_data_i,
  output logic [DATA_W-1:0]        cur_o,
  output logic                     diff_o
);
  logic [DATA_W-1:0] live_w [NUM_IN];
  logic [DATA_W-1:0] copy_q [NUM_IN];

  for (genvar g = 0; g < NUM_IN; g++) begin : g_slot
    assign live_w[g] = in_data_i[g*DATA_W +: DATA_W];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                copy_q[g] <= '0;
      else if (upd_i && (sel_i == IDX_W'(g)))     copy_q[g] <= upd_data_i;
    end
  end

  assign cur_o  = live_w[sel_i];
  assign diff_o = live_w[sel_i] != copy_q[sel_i];
endmodule

// File: rtl/chg_io_seq.sv
module chg_io_seq
  import chg_io_pkg::*;
#(
  parameter int              NUM_IN   = 4,
  parameter int              DATA_W   = 8,
  parameter int              ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] IN_BASE  = 16'h0100,
  parameter logic [ADDR_W-1:0] RES_ADDR = 16'h0200,
  localparam int             IDX_W    = (NUM_IN > 1) ? $clog2(NUM_IN) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scan_req_i,
  input  logic              fetch_req_i,
  input  logic              diff_i,
  input  logic [DATA_W-1:0] cur_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic              upd_o,
  output logic [DATA_W-1:0] upd_data_o,
  output logic              scan_done_o,
  output logic              changed_o,
  output logic [DATA_W-1:0] res_data_o,
  output logic              res_valid_o,
  output logic              bus_req_o,
  input  logic              bus_gnt_i,
  output logic              bus_we_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  input  logic [DATA_W-1:0] bus_rdata_i
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_IN - 1);

  io_state_t         st_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] wbuf_q;
  logic              any_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      idx_q       <= '0;
      wbuf_q      <= '0;
      any_q       <= 1'b0;
      scan_done_o <= 1'b0;
      changed_o   <= 1'b0;
      res_data_o  <= '0;
      res_valid_o <= 1'b0;
    end else begin
      scan_done_o <= 1'b0;
      res_valid_o <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (scan_req_i) begin
            st_q  <= ST_SCAN;
            idx_q <= '0;
            any_q <= 1'b0;
          end else if (fetch_req_i) begin
            st_q <= ST_READ;
          end
        end
        ST_SCAN: begin
          if (diff_i) begin
            wbuf_q <= cur_i;
            st_q   <= ST_WRITE;
          end else if (idx_q == LAST) begin
            scan_done_o <= 1'b1;
            changed_o   <= any_q;
            st_q        <= ST_IDLE;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        ST_WRITE: begin
          if (bus_gnt_i) begin
            any_q <= 1'b1;
            if (idx_q == LAST) begin
              scan_done_o <= 1'b1;
              changed_o   <= 1'b1;
              st_q        <= ST_IDLE;
            end else begin
              idx_q <= idx_q + 1'b1;
              st_q  <= ST_SCAN;
            end
          end
        end
        ST_READ: begin
          if (bus_gnt_i) begin
            res_data_o  <= bus_rdata_i;
            res_valid_o <= 1'b1;
            st_q        <= ST_IDLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // stored copy follows only a granted write
  assign upd_o       = (st_q == ST_WRITE) && bus_gnt_i;
  assign upd_data_o  = wbuf_q;
  assign idx_o       = idx_q;
  assign bus_req_o   = (st_q == ST_WRITE) || (st_q == ST_READ);
  assign bus_we_o    = (st_q == ST_WRITE);
  assign bus_addr_o  = (st_q == ST_WRITE) ? (IN_BASE + ADDR_W'(idx_q)) : RES_ADDR;
  assign bus_wdata_o = wbuf_q;
endmodule

// File: rtl/chg_io_ctrl.sv
module chg_io_ctrl #(
  parameter int              NUM_IN   = 4,
  parameter int              DATA_W   = 8,
  parameter int              ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] IN_BASE  = 16'h0100,
  parameter logic [ADDR_W-1:0] RES_ADDR = 16'h0200,
  localparam int             IDX_W    = (NUM_IN > 1) ? $clog2(NUM_IN) : 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NUM_IN*DATA_W-1:0] in_data_i,
  input  logic                     scan_req_i,
  input  logic                     fetch_req_i,
  output logic                     scan_done_o,
  output logic                     changed_o,
  output logic [DATA_W-1:0]        res_data_o,
  output logic                     res_valid_o,
  output logic                     bus_req_o,
  input  logic                     bus_gnt_i,
  output logic                     bus_we_o,
  output logic [ADDR_W-1:0]        bus_addr_o,
  output logic [DATA_W-1:0]        bus_wdata_o,
  input  logic [DATA_W-1:0]        bus_rdata_i
);
  logic [IDX_W-1:0]  idx_w;
  logic              upd_w;
  logic [DATA_W-1:0] upd_data_w;
  logic [DATA_W-1:0] cur_w;
  logic              diff_w;

  chg_io_shadow #(.NUM_IN(NUM_IN), .DATA_W(DATA_W)) u_shadow (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .in_data_i  (in_data_i),
    .sel_i      (idx_w),
    .upd_i      (upd_w),
    .upd_data_i (upd_data_w),
    .cur_o      (cur_w),
    .diff_o     (diff_w)
  );

  chg_io_seq #(
    .NUM_IN(NUM_IN), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
    .IN_BASE(IN_BASE), .RES_ADDR(RES_ADDR)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .scan_req_i  (scan_req_i),
    .fetch_req_i (fetch_req_i),
    .diff_i      (diff_w),
    .cur_i       (cur_w),
    .idx_o       (idx_w),
    .upd_o       (upd_w),
    .upd_data_o  (upd_data_w),
    .scan_done_o (scan_done_o),
    .changed_o   (changed_o),
    .res_data_o  (res_data_o),
    .res_valid_o (res_valid_o),
    .bus_req_o   (bus_req_o),
    .bus_gnt_i   (bus_gnt_i),
    .bus_we_o    (bus_we_o),
    .bus_addr_o  (bus_addr_o),
    .bus_wdata_o (bus_wdata_o),
    .bus_rdata_i (bus_rdata_i)
  );
endmodule

// File: rtl/chg_io_ctrl_chk.sv
module chg_io_ctrl_chk #(
  parameter int              NUM_IN   = 4,
  parameter int              DATA_W   = 8,
  parameter int              ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] IN_BASE  = 16'h0100,
  parameter logic [ADDR_W-1:0] RES_ADDR = 16'h0200
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              scan_done_o,
  input logic [DATA_W-1:0] res_data_o,
  input logic              res_valid_o,
  input logic              bus_req_o,
  input logic              bus_gnt_i,
  input logic              bus_we_o,
  input logic [ADDR_W-1:0] bus_addr_o,
  input logic [DATA_W-1:0] bus_wdata_o
);
  localparam logic [ADDR_W-1:0] IN_END = IN_BASE + ADDR_W'(NUM_IN);

  assert_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && !bus_gnt_i |=> bus_req_o && $stable(bus_addr_o)
      && $stable(bus_wdata_o) && $stable(bus_we_o));

  assert_write_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && bus_we_o |-> (bus_addr_o >= IN_BASE) && (bus_addr_o < IN_END));

  assert_done_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scan_done_o |=> !scan_done_o);

  assert_read_addr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && !bus_we_o |-> bus_addr_o == RES_ADDR);

  assert_read_valid_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && bus_gnt_i && !bus_we_o |=> res_valid_o);

  assert_res_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(res_data_o) |-> res_valid_o);

  assert_done_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scan_done_o |-> !bus_req_o && !res_valid_o);
endmodule

bind chg_io_ctrl chg_io_ctrl_chk #(
  .NUM_IN(NUM_IN), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
  .IN_BASE(IN_BASE), .RES_ADDR(RES_ADDR)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .scan_done_o (scan_done_o),
  .res_data_o  (res_data_o),
  .res_valid_o (res_valid_o),
  .bus_req_o   (bus_req_o),
  .bus_gnt_i   (bus_gnt_i),
  .bus_we_o    (bus_we_o),
  .bus_addr_o  (bus_addr_o),
  .bus_wdata_o (bus_wdata_o)
);

// File: tb/chg_io_ctrl_test.sv
module chg_io_ctrl_test;
  localparam int NUM_IN = 4;
  localparam logic [15:0] BASE = 16'h0100;
  localparam logic [15:0] RADR = 16'h0200;
  localparam int NVEC = 8;
  // {inputs, expected write mask, expected changed}
  localparam logic [36:0] VEC [NVEC] = '{
    {32'h00000000, 4'b0000, 1'b0},
    {32'h44332211, 4'b1111, 1'b1},
    {32'h44332211, 4'b0000, 1'b0},
    {32'h44AA2211, 4'b0100, 1'b1},
    {32'h55AA22FF, 4'b1001, 1'b1},
    {32'h00000000, 4'b1111, 1'b1},
    {32'h00000000, 4'b0000, 1'b0},
    {32'h80000001, 4'b1001, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] in_data = '0;
  logic        scan_req = 1'b0, fetch_req = 1'b0;
  logic        scan_done, changed, res_valid, bus_req, bus_we;
  logic        bus_gnt = 1'b0;
  logic [7:0]  res_data, bus_wdata;
  logic [7:0]  bus_rdata = '0;
  logic [15:0] bus_addr;

  int checks = 0, failures = 0, cyc = 0;
  int gnt_delay = 0, wait_cnt = 0;
  int wr_cnt = 0, rd_cnt = 0, done_cnt = 0, valid_cnt = 0, req_cycles = 0;
  logic [15:0] wr_addr [16];
  logic [7:0]  wr_data [16];
  logic [15:0] rd_addr;
  logic        chg_at_done;

  always #2.5 clk = ~clk;

  chg_io_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .in_data_i(in_data),
    .scan_req_i(scan_req), .fetch_req_i(fetch_req),
    .scan_done_o(scan_done), .changed_o(changed),
    .res_data_o(res_data), .res_valid_o(res_valid),
    .bus_req_o(bus_req), .bus_gnt_i(bus_gnt), .bus_we_o(bus_we),
    .bus_addr_o(bus_addr), .bus_wdata_o(bus_wdata), .bus_rdata_i(bus_rdata)
  );

  // bus model and monitor, all at the falling edge
  always @(negedge clk) begin
    if (scan_done) begin done_cnt++; chg_at_done = changed; end
    if (res_valid) valid_cnt++;
    if (bus_req) begin
      req_cycles++;
      if (wait_cnt >= gnt_delay) begin
        bus_gnt = 1'b1;
        wait_cnt = 0;
        if (bus_we) begin
          if (wr_cnt < 16) begin wr_addr[wr_cnt] = bus_addr; wr_data[wr_cnt] = bus_wdata; end
          wr_cnt++;
        end else begin
          rd_addr = bus_addr;
          rd_cnt++;
        end
      end else begin
        bus_gnt = 1'b0;
        wait_cnt++;
      end
    end else begin
      bus_gnt = 1'b0;
      wait_cnt = 0;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pulse_scan();
    @(negedge clk); scan_req = 1'b1;
    @(negedge clk); scan_req = 1'b0;
  endtask

  task automatic wait_done(input int d0);
    for (int t = 0; t < 200 && done_cnt == d0; t++) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R7: reset state
    chk(bus_req == 0 && scan_done == 0 && res_valid == 0, "R7 strobes", {bus_req, scan_done, res_valid}, 0);
    chk(changed == 0, "R7 changed", changed, 0);
    chk(res_data == 0, "R7 res_data", res_data, 0);

    // R1: input change without request
    in_data = 32'hDEADBEEF;
    req_cycles = 0;
    repeat (10) @(negedge clk);
    chk(req_cycles == 0 && done_cnt == 0, "R1 idle quiet", req_cycles, 0);
    in_data = '0;

    // vector table: R2 R3 R4 R5 (R7 via first vectors against zeroed copies)
    for (int v = 0; v < NVEC; v++) begin
      logic [31:0] iv;
      logic [3:0]  m;
      int d0, k;
      iv = VEC[v][36:5]; m = VEC[v][4:1];
      in_data = iv;
      gnt_delay = v % 3;
      wr_cnt = 0;
      d0 = done_cnt;
      pulse_scan();
      wait_done(d0);
      @(negedge clk);
      chk(done_cnt == d0 + 1, "R4 one done pulse", done_cnt - d0, 1);
      chk(chg_at_done == VEC[v][0], "R4 R5 changed flag", chg_at_done, VEC[v][0]);
      chk(wr_cnt == $countones(m), "R2 R3 write count", wr_cnt, $countones(m));
      k = 0;
      for (int i = 0; i < NUM_IN; i++) begin
        if (m[i] && k < wr_cnt) begin
          chk(wr_addr[k] == BASE + 16'(i), "R2 write address order", wr_addr[k], BASE + 16'(i));
          chk(wr_data[k] == iv[i*8 +: 8], "R2 write data", wr_data[k], iv[i*8 +: 8]);
          k++;
        end
      end
    end

    // R6: fetch with delayed grant
    gnt_delay = 2;
    bus_rdata = 8'hA5;
    rd_cnt = 0; valid_cnt = 0;
    @(negedge clk); fetch_req = 1'b1;
    @(negedge clk); fetch_req = 1'b0;
    repeat (8) @(negedge clk);
    chk(rd_cnt == 1 && rd_addr == RADR, "R6 read address", rd_addr, RADR);
    chk(valid_cnt == 1, "R6 single valid pulse", valid_cnt, 1);
    chk(res_data == 8'hA5, "R6 result", res_data, 8'hA5);
    bus_rdata = 8'h3C;
    repeat (5) @(negedge clk);
    chk(res_data == 8'hA5 && !res_valid, "R6 result held", res_data, 8'hA5);

    // R8: scan and fetch together, scan wins, fetch dropped
    gnt_delay = 0;
    rd_cnt = 0; wr_cnt = 0;
    begin
      int d0;
      d0 = done_cnt;
      @(negedge clk); scan_req = 1'b1; fetch_req = 1'b1;
      @(negedge clk); scan_req = 1'b0; fetch_req = 1'b0;
      wait_done(d0);
      repeat (10) @(negedge clk);
      chk(done_cnt == d0 + 1, "R8 scan taken", done_cnt - d0, 1);
      chk(rd_cnt == 0, "R8 fetch dropped", rd_cnt, 0);
    end

    // R9: scan request during a pending read is ignored
    gnt_delay = 6;
    rd_cnt = 0; wr_cnt = 0;
    begin
      int d0;
      d0 = done_cnt;
      @(negedge clk); fetch_req = 1'b1;
      @(negedge clk); fetch_req = 1'b0;
      in_data = 32'h80000077;
      @(negedge clk); scan_req = 1'b1;
      @(negedge clk); scan_req = 1'b0;
      repeat (25) @(negedge clk);
      chk(rd_cnt == 1, "R9 read completed", rd_cnt, 1);
      chk(done_cnt == d0 && wr_cnt == 0, "R9 scan ignored", wr_cnt, 0);
      gnt_delay = 0;
      pulse_scan();
      wait_done(d0);
      @(negedge clk);
      chk(wr_cnt == 1 && wr_addr[0] == BASE && wr_data[0] == 8'h77, "R9 later scan writes pending change", {wr_addr[0], wr_data[0]}, {BASE, 8'h77});
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule